// File: doc/BRIEF.md
# Serial ADC Frame Reader

This controller reads one conversion from a 16-bit sampling converter with a serial output. When a start request arrives, it pulls an active-low chip select low and issues a fixed number of serial clocks. The converter uses the first six of these clocks to acquire its input, so the controller discards whatever the data line shows during them. The next sixteen clocks carry the result, most significant bit first. The controller collects those bits into a word and marks it with a one-cycle valid strobe. It then raises chip select, because the converter only starts a new conversion on a fresh falling edge, and keeps it high for a programmed minimum time.

The frame length is a parameter. A 22-clock frame carries only the result. A 24-clock frame pads the result out to three byte-sized groups. A 38-clock frame keeps chip select low while the converter repeats the same result least significant bit first. In that longer frame the controller captures the second copy, compares it against the first and reports whether the two agree. The serial clock rate comes from a divider input.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is held and just after it, cs_n is 1, sclk is 0, and valid, busy and chk_done are 0.
- R2: sclk is 0 whenever cs_n is 1. Each sclk level, high or low, lasts half_div+1 clock cycles.
- R3: The bits present on sdata at the rising sclk edges 1 to 6 have no effect. The bits at rising edges 7 to 22 form data, with edge 7 giving bit 15 and edge 22 giving bit 0.
- R4: valid is high for exactly one clock cycle, starting in the cycle after the 22nd falling sclk edge. data holds its value until the next frame loads it.
- R5: A frame has exactly FRAME_CLKS rising sclk edges when FRAME_CLKS is 22, 24 or 38. Any other value gives 22 edges. cs_n rises on the same clock edge as the last falling sclk edge.
- R6: Between two frames, cs_n stays high for at least cs_gap clock cycles, and for at least one cycle when cs_gap is 0.
- R7: A start pulse that arrives while a frame or the high time is in progress is remembered. It starts exactly one further frame, and cs_n stays high after that frame if no other start arrives.
- R8: busy is 1 from the cycle after a start pulse until the high time after the last requested frame has elapsed. busy is 1 whenever cs_n is 0.
- R9: With FRAME_CLKS = 38, the rising edges 23 to 38 carry the result again, with edge 23 giving bit 0 and edge 38 giving bit 15. chk_done pulses for one cycle in the cycle cs_n rises. chk_err is then 1 exactly when this second copy differs from data.
- R10: With any frame length other than 38, chk_done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to read one conversion |
| half_div | input | DIV_W | Length of each sclk level, minus one, in clock cycles |
| cs_gap | input | GAP_W | Minimum number of clock cycles that cs_n stays high between frames |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock; idles low |
| data | output | 16 | Last result read |
| valid | output | 1 | One-cycle strobe that marks a new value on data |
| busy | output | 1 | A frame is requested, in progress, or in its high time |
| chk_done | output | 1 | One-cycle strobe when the verify comparison has finished |
| chk_err | output | 1 | Second copy disagreed with the first; read it with chk_done |

## Verification
The embedded properties check the following on every cycle:
- sclk is low whenever chip select is high.
- valid lasts a single cycle.
- Chip select rises only after the full clock count.
- busy is high during every frame.
- Chip select stays high for at least the programmed time.
- The verify strobe coincides with the release of chip select.

Only the bench scenarios can show the rest: that the ignored sampling bits and the padding bits leave the word alone, that the word is assembled in the right order for several bit patterns, that the divider sets the clock width, that a corrupted second stream is detected, that a request made during a frame is held, and that an unsupported frame length is clamped.

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int FRAME_CLKS = 22,
  parameter int DIV_W      = 8,
  parameter int GAP_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] half_div,
  input  logic [GAP_W-1:0] cs_gap,
  input  logic             sdata,
  output logic             cs_n,
  output logic             sclk,
  output logic [15:0]      data,
  output logic             valid,
  output logic             busy,
  output logic             chk_done,
  output logic             chk_err
);

  localparam int NCLK   = (FRAME_CLKS == 24 || FRAME_CLKS == 38) ? FRAME_CLKS : 22;
  localparam bit VERIFY = (NCLK == 38);
  localparam logic [5:0] E_LEAD  = 6'd6;
  localparam logic [5:0] E_LAST  = 6'd22;
  localparam logic [5:0] E_REPT  = 6'd38;
  localparam logic [5:0] E_NCLK  = 6'(NCLK);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} st_t;

  st_t              st;
  logic             pend;
  logic [DIV_W-1:0] dcnt;
  logic [5:0]       ecnt;
  logic [GAP_W-1:0] gcnt;
  logic [15:0]      sh, rv;

  assign cs_n = (st != S_RUN);
  assign busy = (st != S_IDLE) | pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pend     <= 1'b0;
      sclk     <= 1'b0;
      dcnt     <= '0;
      ecnt     <= '0;
      gcnt     <= '0;
      sh       <= '0;
      rv       <= '0;
      data     <= '0;
      valid    <= 1'b0;
      chk_done <= 1'b0;
      chk_err  <= 1'b0;
    end else begin
      valid    <= 1'b0;
      chk_done <= 1'b0;
      if (start) pend <= 1'b1;
      else if (st == S_IDLE && pend) pend <= 1'b0;
      case (st)
        S_IDLE: if (pend) begin
          st   <= S_RUN;
          ecnt <= '0;
          dcnt <= '0;
          sclk <= 1'b0;
        end
        S_RUN: begin
          if (dcnt == half_div) begin
            dcnt <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
              if (ecnt >= E_LEAD && ecnt < E_LAST) sh <= {sh[14:0], sdata};
              if (VERIFY && ecnt >= E_LAST && ecnt < E_REPT) rv <= {sdata, rv[15:1]};
            end else begin
              sclk <= 1'b0;
              ecnt <= ecnt + 6'd1;
              if (ecnt == E_LAST - 6'd1) begin
                data  <= sh;
                valid <= 1'b1;
              end
              if (ecnt == E_NCLK - 6'd1) begin
                st   <= S_GAP;
                gcnt <= GAP_W'(1);
                if (VERIFY) begin
                  chk_done <= 1'b1;
                  chk_err  <= (rv != data);
                end
              end
            end
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        default: begin
          if (gcnt >= cs_gap) st <= S_IDLE;
          else gcnt <= gcnt + 1'b1;
        end
      endcase
    end
  end

  logic [GAP_W:0] hcnt;
  logic           framed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt   <= '0;
      framed <= 1'b0;
    end else begin
      if (cs_n) begin
        if (hcnt != '1) hcnt <= hcnt + 1'b1;
      end else begin
        hcnt   <= '0;
        framed <= 1'b1;
      end
    end
  end

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_frame_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (ecnt == E_NCLK && !sclk));

  assert_gap_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (framed && $fell(cs_n)) |-> (hcnt >= {1'b0, cs_gap} && hcnt != '0));

  assert_busy_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  assert_chk_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |-> $rose(cs_n));

  assert_no_chk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !VERIFY |-> !chk_done);

endmodule

// File: tb/adc_frame_reader_bench.sv
module adc_frame_reader_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, start2, corrupt;
  logic [7:0] half_div, cs_gap;
  logic [15:0] word;
  logic cs_n, sclk, sdata, valid, busy, chk_done, chk_err;
  logic [15:0] data;
  logic cs2, sclk2, valid2, busy2, done2, err2;
  logic [15:0] data2;
  int rises = 0, rises2 = 0, run = 0, hi_len = 0;
  int checks = 0, fails = 0;
  bit done2_seen = 0;

  adc_frame_reader #(.FRAME_CLKS(38)) u_adc_frame_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .half_div(half_div), .cs_gap(cs_gap),
    .sdata(sdata), .cs_n(cs_n), .sclk(sclk), .data(data), .valid(valid),
    .busy(busy), .chk_done(chk_done), .chk_err(chk_err));

  adc_frame_reader #(.FRAME_CLKS(30)) u_clamp (
    .clk(clk), .rst_n(rst_n), .start(start2), .half_div(half_div), .cs_gap(cs_gap),
    .sdata(1'b0), .cs_n(cs2), .sclk(sclk2), .data(data2), .valid(valid2),
    .busy(busy2), .chk_done(done2), .chk_err(err2));

  always @(negedge cs_n) rises = 0;
  always @(posedge sclk) rises = rises + 1;
  always @(negedge cs2) rises2 = 0;
  always @(posedge sclk2) rises2 = rises2 + 1;
  always @(posedge clk) if (done2) done2_seen = 1;

  always @(negedge clk) begin
    if (sclk) run = run + 1;
    else if (run != 0) begin hi_len = run; run = 0; end
  end

  function automatic logic model_bit(int k);
    if (k >= 7 && k <= 22) return word[22-k];
    if (k >= 23 && k <= 38) return word[k-23] ^ (corrupt && k == 30);
    return 1'b1;
  endfunction
  assign sdata = model_bit(rises + 1);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  localparam logic [23:0] VEC [5] = '{
    {16'hA5C3, 8'd0}, {16'h0001, 8'd1}, {16'h8000, 8'd3},
    {16'hFFFF, 8'd0}, {16'h0000, 8'd2}};

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; start2 = 0; corrupt = 0;
    half_div = 0; cs_gap = 8'd5; word = 0;
    repeat (3) @(negedge clk);
    check("R1 cs_n", cs_n, 1); check("R1 sclk", sclk, 0);
    check("R1 valid", valid, 0); check("R1 busy", busy, 0);
    check("R1 chk_done", chk_done, 0);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[i]) begin
      word = VEC[i][23:8];
      half_div = VEC[i][7:0];
      pulse(start);
      check("R8 busy after start", busy, 1);
      while (!valid) @(negedge clk);
      check("R3 data", data, word);
      @(negedge clk);
      check("R4 valid one cycle", valid, 0);
      @(negedge clk);
      check("R2 sclk high width", hi_len, 32'(half_div) + 1);
      while (!chk_done) @(negedge clk);
      check("R9 no mismatch", chk_err, 0);
      check("R5 clock count 38", rises, 38);
      check("R8 busy during gap", busy, 1);
      check("R4 data held", data, word);
      while (busy) @(negedge clk);
    end

    corrupt = 1; word = 16'h1234; half_div = 0;
    pulse(start);
    while (!chk_done) @(negedge clk);
    check("R9 mismatch flagged", chk_err, 1);
    check("R3 first copy intact", data, 16'h1234);
    corrupt = 0;
    while (busy) @(negedge clk);

    word = 16'h5AF0;
    pulse(start);
    while (cs_n) @(negedge clk);
    pulse(start);
    while (!chk_done) @(negedge clk);
    begin
      int hi = 0;
      while (cs_n && hi < 100) begin hi++; @(negedge clk); end
      check("R7 pending frame started", cs_n, 0);
      check("R6 gap at least cs_gap", (hi >= 5 && hi <= 7), 1);
    end
    while (!valid) @(negedge clk);
    check("R7 second frame data", data, 16'h5AF0);
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    check("R7 no extra frame", cs_n, 1);

    pulse(start2);
    while (!valid2) @(negedge clk);
    check("R3 clamp data", data2, 16'h0000);
    while (!cs2) @(negedge clk);
    check("R5 clamped to 22 clocks", rises2, 22);
    repeat (10) @(negedge clk);
    check("R10 no chk_done", done2_seen, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule